// File: doc/BRIEF.md
# Quad-Rate Burst-of-Four Static Memory Model

This block is a synthesizable behavioural model of a static memory with one read data port and one write data port, each of which moves a burst of four words per access. Commands arrive once per main clock period. Data beats land on both the main clock edge and the complement edge. The model runs on a single internal clock at twice the command rate, and a phase flag marks which internal edges stand for main-clock edges.

A write command names a burst base address. Its four data words are taken over the next two command periods. A read command names a burst base, and its four words come out after a fixed delay. A parameter selects either a two-period or a two-and-a-half-period read delay. A second request of the same kind on the command edge directly after an accepted one is dropped. A read and a write may be accepted on the same command edge, and their bursts run side by side. The read port carries an output-enable flag that is low whenever no read beat is being driven, which stands in for the high-impedance state.

Edges are counted on the internal clock from the command edge, which is edge 0. Even-numbered edges are main-clock edges and odd-numbered edges are complement edges.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is held, `rdata_oe` is 0, `rdata` is 0 and `k_slot` is 1, so the first internal edge after reset is a main-clock edge.
- R2: `k_slot` alternates on every internal clock edge. A value of 1 means the coming edge is a main-clock edge, the only kind on which `rd_n` and `wr_n` are sampled.
- R3: An accepted write to burst base B stores the `wdata` present at edges 2, 3, 4 and 5 into word addresses 4B+0, 4B+1, 4B+2 and 4B+3. Outside those edges, `wdata` is not stored.
- R4: With the two-period delay setting, an accepted read of base B drives words 4B+0 to 4B+3 on `rdata` at edges 4, 5, 6 and 7, with `rdata_oe` high exactly on those beats.
- R5: With the two-and-a-half-period delay setting, the same four words are driven at edges 5, 6, 7 and 8.
- R6: A command edge with both `rd_n` and `wr_n` high starts nothing. `rdata_oe` stays low when no beat is scheduled, and `rdata` holds its last value while `rdata_oe` is low.
- R7: A read request on the command edge right after an accepted read is ignored and produces no output beats.
- R8: A write request on the command edge right after an accepted write is ignored, and its data never reaches the array.
- R9: A read and a write accepted on the same command edge both complete.
- R10: A read beat sees only data stored by earlier edges. A write beat to the same word on the same edge is not forwarded.
- R11: While the clock is stopped, `rdata`, `rdata_oe` and `k_slot` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the command rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_n | input | 1 | Active-low read request, sampled on main-clock edges |
| wr_n | input | 1 | Active-low write request, sampled on main-clock edges |
| burst_addr | input | AW-2 | Burst base address (word address divided by four) |
| wdata | input | DW | Write data beat |
| rdata | output | DW | Read data beat |
| rdata_oe | output | 1 | High while a read beat is driven |
| k_slot | output | 1 | High when the coming internal edge is a main-clock edge |

## Verification
The hardest case to reach is a read beat and a write beat hitting the same word on the same internal edge. That only happens when a write to the read's base is issued exactly one command period after the read. The bench issues this pair on purpose and expects the old contents on all four beats with the two-period delay. The other collision, locked-out requests, is reached by back-to-back reads and back-to-back writes. For the writes, the dropped burst's address is read back afterwards.

// File: rtl/qdr_pkg.sv
`timescale 1ns/1ps
package qdr_pkg;
    // read delay setting, in command periods
    typedef enum logic {
        LAT_2P0 = 1'b0,
        LAT_2P5 = 1'b1
    } lat_e;

    localparam int BEATS = 4;
endpackage

// File: rtl/qdr_req_gate.sv
`timescale 1ns/1ps
// accepts an active-low request on a main-clock edge unless the same kind was accepted on the previous one
module qdr_req_gate (
    input  logic k_edge,
    input  logic req_n,
    input  logic prev_acc,
    output logic acc
);
    always_comb begin
        acc = k_edge & ~req_n & ~prev_acc;
    end
endmodule

// File: rtl/qdr_cmd_pipe.sv
`timescale 1ns/1ps
// per-edge delay line of accepted commands; exports taps LO..DEPTH-1
module qdr_cmd_pipe #(
    parameter int BW    = 6,
    parameter int DEPTH = 8,
    parameter int LO    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_vld,
    input  logic [BW-1:0]                in_base,
    output logic                         prev_acc_o,
    output logic [DEPTH-1:LO]            vld_o,
    output logic [DEPTH-1:LO][BW-1:0]    base_o
);
    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0][BW-1:0] base;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        pipe_d.vld[0]  = in_vld;
        pipe_d.base[0] = in_base;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d.vld[i]  = pipe_q.vld[i-1];
            pipe_d.base[i] = pipe_q.base[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    // tap 1 holds the command accepted one main period ago
    assign prev_acc_o = pipe_q.vld[1];

    generate
        for (genvar g = LO; g < DEPTH; g++) begin : g_tap
            assign vld_o[g]  = pipe_q.vld[g];
            assign base_o[g] = pipe_q.base[g];
        end
    endgenerate
endmodule

// File: rtl/qdr_mem_array.sv
`timescale 1ns/1ps
// word array: registered write, combinational read of the old contents
module qdr_mem_array #(
    parameter int DW = 18,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/qdr_burst_sram.sv
`timescale 1ns/1ps
module qdr_burst_sram #(
    parameter int           DW  = 18,
    parameter int           AW  = 8,
    parameter qdr_pkg::lat_e LAT = qdr_pkg::LAT_2P0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [AW-3:0]   burst_addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            rdata_oe,
    output logic            k_slot
);
    localparam int BW       = AW - 2;
    localparam int BEATS    = qdr_pkg::BEATS;
    localparam int WR_LO    = 1;
    localparam int WR_DEPTH = WR_LO + BEATS;
    localparam int RD_LO    = (LAT == qdr_pkg::LAT_2P5) ? 4 : 3;
    localparam int RD_DEPTH = RD_LO + BEATS;

    typedef struct packed {
        logic          phase;   // 0: this edge is a main-clock edge
        logic          oe;
        logic [DW-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic k_edge;
    logic rd_acc, wr_acc;
    logic rd_prev, wr_prev;

    logic [RD_DEPTH-1:RD_LO]         rd_vld;
    logic [RD_DEPTH-1:RD_LO][BW-1:0] rd_base;
    logic [WR_DEPTH-1:WR_LO]         wr_vld;
    logic [WR_DEPTH-1:WR_LO][BW-1:0] wr_base;

    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] mem_raddr;
    logic [DW-1:0] mem_rd;
    logic          rd_beat;

    assign k_edge = ~st_q.phase;

    qdr_req_gate u_rd_gate (
        .k_edge   (k_edge),
        .req_n    (rd_n),
        .prev_acc (rd_prev),
        .acc      (rd_acc)
    );

    qdr_req_gate u_wr_gate (
        .k_edge   (k_edge),
        .req_n    (wr_n),
        .prev_acc (wr_prev),
        .acc      (wr_acc)
    );

    qdr_cmd_pipe #(
        .BW    (BW),
        .DEPTH (RD_DEPTH),
        .LO    (RD_LO)
    ) u_rd_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (rd_acc),
        .in_base    (burst_addr),
        .prev_acc_o (rd_prev),
        .vld_o      (rd_vld),
        .base_o     (rd_base)
    );

    qdr_cmd_pipe #(
        .BW    (BW),
        .DEPTH (WR_DEPTH),
        .LO    (WR_LO)
    ) u_wr_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (wr_acc),
        .in_base    (burst_addr),
        .prev_acc_o (wr_prev),
        .vld_o      (wr_vld),
        .base_o     (wr_base)
    );

    qdr_mem_array #(
        .DW (DW),
        .AW (AW)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wdata),
        .raddr (mem_raddr),
        .rdata (mem_rd)
    );

    // lockout keeps at most one live command in each tap window
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = '0;
        rd_beat   = 1'b0;
        mem_raddr = '0;
        for (int b = 0; b < BEATS; b++) begin
            if (wr_vld[WR_LO+b]) begin
                mem_we    = 1'b1;
                mem_waddr = {wr_base[WR_LO+b], 2'(b)};
            end
            if (rd_vld[RD_LO+b]) begin
                rd_beat   = 1'b1;
                mem_raddr = {rd_base[RD_LO+b], 2'(b)};
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        st_d.oe    = rd_beat;
        if (rd_beat) begin
            st_d.rdata = mem_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.rdata;
    assign rdata_oe = st_q.oe;
    assign k_slot   = ~st_q.phase;
endmodule

// File: rtl/qdr_burst_sram_chk.sv
`timescale 1ns/1ps
module qdr_burst_sram_chk #(
    parameter int            DW  = 18,
    parameter qdr_pkg::lat_e LAT = qdr_pkg::LAT_2P0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          k_slot,
    input logic          rdata_oe,
    input logic [DW-1:0] rdata,
    input logic          rd_acc,
    input logic          wr_acc
);
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rdata_oe && k_slot));

    p_phase_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (k_slot != $past(k_slot)));

    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !rdata_oe) |-> $stable(rdata));

    p_rd_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |-> ##2 !rd_acc);

    p_wr_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |-> ##2 !wr_acc);

    generate
        if (LAT == qdr_pkg::LAT_2P5) begin : g_lat25
            p_burst_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
                rd_acc |-> ##6 rdata_oe ##1 rdata_oe ##1 rdata_oe ##1 rdata_oe);
        end else begin : g_lat20
            p_burst_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
                rd_acc |-> ##5 rdata_oe ##1 rdata_oe ##1 rdata_oe ##1 rdata_oe);
        end
    endgenerate
endmodule

bind qdr_burst_sram qdr_burst_sram_chk #(
    .DW  (DW),
    .LAT (LAT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .k_slot   (k_slot),
    .rdata_oe (rdata_oe),
    .rdata    (rdata),
    .rd_acc   (rd_acc),
    .wr_acc   (wr_acc)
);

// File: tb/qdr_burst_sram_tb.sv
`timescale 1ns/1ps
module qdr_burst_sram_tb;
    localparam int DW    = 18;
    localparam int AW    = 8;
    localparam int BW    = AW - 2;
    localparam int NE    = 1024;
    localparam int NROWS = 22;

    // row: {rd, wr, base[5:0], seed[7:0]}
    localparam logic [15:0] TABLE [NROWS] = '{
        {1'b1, 1'b0, 6'd4,  8'd0},
        {1'b0, 1'b0, 6'd0,  8'd0},
        {1'b1, 1'b0, 6'd8,  8'd0},
        {1'b0, 1'b0, 6'd0,  8'd0},
        {1'b1, 1'b0, 6'd17, 8'd0},
        {1'b0, 1'b0, 6'd0,  8'd0},
        {1'b1, 1'b0, 6'd1,  8'd0},
        {1'b0, 1'b0, 6'd0,  8'd0},
        {1'b0, 1'b1, 6'd4,  8'd100},
        {1'b1, 1'b0, 6'd4,  8'd0},
        {1'b0, 1'b0, 6'd0,  8'd0},
        {1'b1, 1'b1, 6'd32, 8'd101},
        {1'b0, 1'b0, 6'd0,  8'd0},
        {1'b1, 1'b1, 6'd63, 8'd102},
        {1'b1, 1'b1, 6'd5,  8'd103},
        {1'b0, 1'b0, 6'd0,  8'd0},
        {1'b1, 1'b0, 6'd63, 8'd0},
        {1'b0, 1'b0, 6'd0,  8'd0},
        {1'b1, 1'b0, 6'd5,  8'd0},
        {1'b0, 1'b0, 6'd0,  8'd0},
        {1'b0, 1'b0, 6'd0,  8'd0},
        {1'b0, 1'b0, 6'd0,  8'd0}
    };

    logic          clk = 1'b0;
    logic          clk_run = 1'b1;
    logic          rst_n = 1'b0;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [BW-1:0] burst_addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd20, rd25;
    logic          oe20, oe25, ks20, ks25;

    always begin
        #2;
        if (clk_run) clk = ~clk;
    end

    qdr_burst_sram #(.DW(DW), .AW(AW), .LAT(qdr_pkg::LAT_2P0)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .burst_addr(burst_addr),
        .wdata(wdata), .rdata(rd20), .rdata_oe(oe20), .k_slot(ks20)
    );

    qdr_burst_sram #(.DW(DW), .AW(AW), .LAT(qdr_pkg::LAT_2P5)) u_dut_h (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .burst_addr(burst_addr),
        .wdata(wdata), .rdata(rd25), .rdata_oe(oe25), .k_slot(ks25)
    );

    int    checks = 0;
    int    errors = 0;
    int    n = 0;
    bit    done = 0;
    bit    last_rd = 0;
    bit    last_wr = 0;
    string cur_tag = "R4";

    logic [DW-1:0] refmem [1 << AW];
    bit            wv   [NE];
    logic [AW-1:0] wa   [NE];
    logic [DW-1:0] wd   [NE];
    bit            r2v  [NE];
    logic [AW-1:0] r2a  [NE];
    bit            r5v  [NE];
    logic [AW-1:0] r5a  [NE];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at edge %0d: actual=%0h expected=%0h", tag, what, n, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] beat_data(input int seed, input int b);
        return DW'(seed * 16 + b + 1);
    endfunction

    // one internal edge: reference reads old contents first, then applies the write beat
    task automatic step_edge();
        logic [DW-1:0] e2d, e5d;
        @(posedge clk);
        @(negedge clk);
        e2d = r2v[n] ? refmem[r2a[n]] : '0;
        e5d = r5v[n] ? refmem[r5a[n]] : '0;
        if (wv[n]) refmem[wa[n]] = wd[n];
        chk(oe20 === r2v[n], cur_tag, "oe (2.0)", longint'(oe20), longint'(r2v[n]));
        if (r2v[n]) chk(rd20 === e2d, cur_tag, "rdata (2.0)", longint'(rd20), longint'(e2d));
        chk(oe25 === r5v[n], "R5", "oe (2.5)", longint'(oe25), longint'(r5v[n]));
        if (r5v[n]) chk(rd25 === e5d, "R5", "rdata (2.5)", longint'(rd25), longint'(e5d));
        chk(ks20 === ((n % 2) == 1), "R2", "k_slot", longint'(ks20), longint'((n % 2) == 1));
        n++;
    endtask

    task automatic drive_wdata();
        wdata = wv[n] ? wd[n] : DW'(18'h2AAAA ^ n);
    endtask

    // one command period: main-clock edge then complement edge
    task automatic do_cycle(input bit rd, input bit wr, input logic [BW-1:0] base, input int seed);
        bit rd_ok, wr_ok;
        rd_ok = rd && !last_rd;
        wr_ok = wr && !last_wr;
        last_rd = rd_ok;
        last_wr = wr_ok;
        for (int b = 0; b < 4; b++) begin
            if (wr_ok) begin
                wv[n+2+b] = 1'b1;
                wa[n+2+b] = {base, 2'(b)};
                wd[n+2+b] = beat_data(seed, b);
            end
            if (rd_ok) begin
                r2v[n+4+b] = 1'b1;
                r2a[n+4+b] = {base, 2'(b)};
                r5v[n+5+b] = 1'b1;
                r5a[n+5+b] = {base, 2'(b)};
            end
        end
        rd_n = !rd;
        wr_n = !wr;
        burst_addr = base;
        drive_wdata();
        step_edge();
        drive_wdata();
        step_edge();
    endtask

    task automatic nops(input int k);
        for (int i = 0; i < k; i++) do_cycle(1'b0, 1'b0, '0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #600000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [DW-1:0] hold_d;
        logic          hold_oe, hold_ks;
        for (int i = 0; i < NE; i++) begin
            wv[i] = 0; r2v[i] = 0; r5v[i] = 0;
            wa[i] = '0; wd[i] = '0; r2a[i] = '0; r5a[i] = '0;
        end
        for (int i = 0; i < (1 << AW); i++) refmem[i] = '0;

        // R1: outputs during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(oe20 === 1'b0, "R1", "oe in reset", longint'(oe20), 0);
            chk(rd20 === '0, "R1", "rdata in reset", longint'(rd20), 0);
            chk(ks20 === 1'b1, "R1", "k_slot in reset", longint'(ks20), 1);
        end
        rst_n = 1'b1;

        // R3: fill every burst, one write every other period
        cur_tag = "R3";
        for (int i = 0; i < (1 << BW); i++) begin
            do_cycle(1'b0, 1'b1, BW'(i), i);
            do_cycle(1'b0, 1'b0, '0, 0);
        end

        // table walk: R4 reads, R6 idle rows, R9 read+write rows
        for (int r = 0; r < NROWS; r++) begin
            logic [15:0] row;
            row = TABLE[r];
            if (row[15] && row[14]) cur_tag = "R9";
            else if (!row[15] && !row[14]) cur_tag = "R6";
            else cur_tag = "R4";
            do_cycle(row[15], row[14], row[13:8], int'(row[7:0]));
        end

        // R7: second read on the next command edge gives no beats
        cur_tag = "R7";
        do_cycle(1'b1, 1'b0, 6'd12, 0);
        do_cycle(1'b1, 1'b0, 6'd20, 0);
        nops(5);

        // R8: second write dropped; its base keeps the fill data
        cur_tag = "R8";
        do_cycle(1'b0, 1'b1, 6'd24, 110);
        do_cycle(1'b0, 1'b1, 6'd25, 111);
        nops(3);
        do_cycle(1'b1, 1'b0, 6'd25, 0);
        nops(2);
        do_cycle(1'b1, 1'b0, 6'd24, 0);
        nops(5);

        // R10: write one period after a read of the same base is not forwarded
        cur_tag = "R10";
        do_cycle(1'b1, 1'b0, 6'd28, 0);
        do_cycle(1'b0, 1'b1, 6'd28, 120);
        nops(5);
        do_cycle(1'b1, 1'b0, 6'd28, 0);
        nops(5);

        // R11: stop the clock in the middle of a read burst
        cur_tag = "R11";
        do_cycle(1'b1, 1'b0, 6'd36, 0);
        nops(2);
        hold_d = rd20;
        hold_oe = oe20;
        hold_ks = ks20;
        clk_run = 1'b0;
        #40;
        chk(rd20 === hold_d, "R11", "rdata held", longint'(rd20), longint'(hold_d));
        chk(oe20 === hold_oe, "R11", "oe held", longint'(oe20), longint'(hold_oe));
        chk(ks20 === hold_ks, "R11", "k_slot held", longint'(ks20), longint'(hold_ks));
        chk(oe20 === 1'b1, "R11", "burst live at stop", longint'(oe20), 1);
        clk_run = 1'b1;
        nops(6);

        finish_run();
    end
endmodule